// File: doc/BRIEF.md
# Watchdog Timer with Selectable Postscaler

This block is a watchdog that counts ticks from a slow on-chip oscillator, arriving as a one-cycle enable `osc_tick` in the system clock domain. A fixed divider of `BASE_DIV` ticks sets the base period. A binary postscaler then extends that period by a power of two, chosen by a 4-bit select. If software does not service the watchdog within the chosen window, the block issues a one-cycle pulse. That pulse is a watchdog reset when the core is running, or a wake-up request when the core sits in a power-managed mode.

Several events restart the count: a service strobe, entry into sleep, a detected clock failure, and device reset. The watchdog runs whenever a hardware enable bit is set. Software can turn it on only while that bit is clear, and it can never turn off a watchdog that hardware has enabled.

Top module: `wdog_timer`

## Requirements
- R1: The watchdog is active when `hw_en` is 1, whatever the value of `sw_en`. When `hw_en` is 0, `sw_en` = 1 activates it and `sw_en` = 0 leaves it inactive.
- R2: While inactive, both counters are held at zero and neither output pulses. After reactivation, a full period is counted from zero.
- R3: From a cleared state, a timeout fires on the `BASE_DIV * 2^ps_sel`-th tick, where `BASE_DIV` defaults to 128. The output pulse is high during the clock cycle after the edge that samples that tick.
- R4: `ps_sel` value k selects a postscaler ratio of 2^k. Value 0 gives 1:1 and value 15 gives 1:32768.
- R5: A `clr_strobe` restarts both the base divider and the postscaler from zero.
- R6: A `sleep_strobe` restarts both counters from zero.
- R7: A `clk_fail` cycle restarts both counters from zero.
- R8: Asserting `rst_n` low clears both counters and both outputs asynchronously.
- R9: A timeout with `in_pm` = 0 produces a one-cycle `wdt_reset` pulse, and `wdt_wake` stays low.
- R10: A timeout with `in_pm` = 1 produces a one-cycle `wdt_wake` pulse, and `wdt_reset` stays low.
- R11: After a timeout both counters restart, so the next timeout follows after another full period.
- R12: A restart event (R5 to R7) in the same cycle as a tick takes priority. That tick is not counted and cannot cause a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| osc_tick | input | 1 | One-cycle enable per slow-oscillator period |
| hw_en | input | 1 | Hardware enable bit |
| sw_en | input | 1 | Software enable bit, effective only while `hw_en` is 0 |
| clr_strobe | input | 1 | Service (clear-watchdog) strobe |
| sleep_strobe | input | 1 | Sleep-entry strobe |
| clk_fail | input | 1 | Clock-failure flag |
| in_pm | input | 1 | Core is in a power-managed mode |
| ps_sel | input | 4 | Postscaler tap select, ratio 2^ps_sel |
| wdt_reset | output | 1 | One-cycle watchdog reset pulse |
| wdt_wake | output | 1 | One-cycle wake-up pulse |

## Verification
A service strobe and the final tick of a period can land in the same cycle, and the block must then choose between restarting and timing out. The bench counts up to one tick short of the period. It then raises `osc_tick` and `clr_strobe` together for a single cycle. The result is judged correct only if no pulse appears on either output and a complete fresh period of ticks is then needed before the next timeout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Registered state of the timeout output stage.
    typedef struct packed {
        logic rst_pls;
        logic wake_pls;
    } wd_out_st_t;

    // Number of postscaler counter bits needed for a given tap count.
    function automatic int ps_cnt_bits(input int ps_w);
        return (ps_w > 1) ? ps_w - 1 : 1;
    endfunction

endpackage

// File: rtl/wdog_base_div.sv
module wdog_base_div #(
    parameter int BASE_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic carry
);
    localparam int CW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(BASE_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        carry = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == LAST) begin
                carry    = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: base count never leaves its range
    a_r3_base_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    // R5: a restart leaves the divider at zero
    a_r5_base_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.cnt == '0);

endmodule

// File: rtl/wdog_postscaler.sv
module wdog_postscaler #(
    parameter int PS_W  = 16,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    import wdog_pkg::*;

    localparam int CW   = ps_cnt_bits(PS_W);
    localparam int NTAP = 2 ** SEL_W;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t             st_d, st_q;
    logic [NTAP-1:0] tap;

    // tap[i] is high when the low i bits are all ones, i.e. 2^i carries seen
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        if (i == 0) begin : g_first
            assign tap[i] = 1'b1;
        end else if (i <= CW) begin : g_mid
            assign tap[i] = &st_q.cnt[i-1:0];
        end else begin : g_clamp
            assign tap[i] = &st_q.cnt;
        end
    end

    always_comb begin
        st_d = st_q;
        hit  = adv & tap[sel];
        if (clr) begin
            st_d.cnt = '0;
        end else if (adv) begin
            if (hit) st_d.cnt = '0;
            else     st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: counting restarts from zero after a timeout
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> st_q.cnt == '0);
    // R5: a restart leaves the postscaler at zero
    a_r5_ps_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.cnt == '0);

endmodule

// File: rtl/wdog_evt_out.sv
module wdog_evt_out (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic in_pm,
    output logic rst_pls,
    output logic wake_pls
);
    import wdog_pkg::*;

    wd_out_st_t st_d, st_q;

    always_comb begin
        st_d          = '0;
        st_d.rst_pls  = hit & ~in_pm;
        st_d.wake_pls = hit & in_pm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_pls  = st_q.rst_pls;
    assign wake_pls = st_q.wake_pls;

    // R9 / R10: at most one kind of pulse at a time
    a_r9_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rst_pls, wake_pls}) <= 1);
    // R10: a wake pulse only follows a power-managed cycle
    a_r10_wake_in_pm: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pls |-> $past(in_pm));
    // R9: a reset pulse only follows a running cycle
    a_r9_reset_awake: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pls |-> !$past(in_pm));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int BASE_DIV = 128,
    parameter int PS_W     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       hw_en,
    input  logic       sw_en,
    input  logic       clr_strobe,
    input  logic       sleep_strobe,
    input  logic       clk_fail,
    input  logic       in_pm,
    input  logic [3:0] ps_sel,
    output logic       wdt_reset,
    output logic       wdt_wake
);
    localparam int SEL_W = 4;

    logic run, restart, base_carry, ps_hit;

    // R1: software may only switch the watchdog on while hardware has it off
    assign run     = hw_en | sw_en;
    // R2, R5, R6, R7: every restart source, plus the inactive state
    assign restart = ~run | clr_strobe | sleep_strobe | clk_fail;

    wdog_base_div #(.BASE_DIV(BASE_DIV)) i_base (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .tick  (osc_tick),
        .carry (base_carry)
    );

    wdog_postscaler #(.PS_W(PS_W), .SEL_W(SEL_W)) i_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .adv   (base_carry),
        .sel   (ps_sel),
        .hit   (ps_hit)
    );

    wdog_evt_out i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (ps_hit),
        .in_pm    (in_pm),
        .rst_pls  (wdt_reset),
        .wake_pls (wdt_wake)
    );

    // R2: no pulse follows an inactive cycle
    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_en || sw_en) |=> !wdt_reset && !wdt_wake);
    // R12: a restart cycle never yields a timeout
    a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_strobe || sleep_strobe || clk_fail) |=> !wdt_reset && !wdt_wake);
    // R3: a pulse needs a tick in the cycle before
    a_r3_tick_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_reset || wdt_wake) |-> $past(osc_tick));

    if (BASE_DIV > 1) begin : g_pulse_chk
        // R9 / R10: pulses last a single cycle
        a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (wdt_reset || wdt_wake) |=> !wdt_reset && !wdt_wake);
    end

endmodule

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
    localparam int BD = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic osc_tick = 0, hw_en = 0, sw_en = 0, clr_strobe = 0;
    logic sleep_strobe = 0, clk_fail = 0, in_pm = 0;
    logic [3:0] ps_sel = 0;
    logic wdt_reset, wdt_wake;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdog_timer #(.BASE_DIV(BD), .PS_W(16)) i_wdog_timer (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .hw_en(hw_en),
        .sw_en(sw_en), .clr_strobe(clr_strobe), .sleep_strobe(sleep_strobe),
        .clk_fail(clk_fail), .in_pm(in_pm), .ps_sel(ps_sel),
        .wdt_reset(wdt_reset), .wdt_wake(wdt_wake)
    );

    // {sel[26:23], hw[22], sw[21], pm[20], gap[19:18], expected ticks[17:0]}
    // expected 0 means no timeout at all
    localparam int NV = 8;
    localparam logic [26:0] VEC [NV] = '{
        {4'd0,  1'b1, 1'b0, 1'b0, 2'd1, 18'd2},
        {4'd1,  1'b0, 1'b1, 1'b0, 2'd1, 18'd4},
        {4'd3,  1'b1, 1'b1, 1'b1, 2'd3, 18'd16},
        {4'd5,  1'b1, 1'b0, 1'b1, 2'd1, 18'd64},
        {4'd0,  1'b0, 1'b0, 1'b0, 2'd1, 18'd0},
        {4'd7,  1'b0, 1'b1, 1'b0, 2'd2, 18'd256},
        {4'd4,  1'b1, 1'b0, 1'b1, 2'd1, 18'd32},
        {4'd15, 1'b1, 1'b0, 1'b0, 2'd1, 18'd65536}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 none, 1 reset, 2 wake, 3 both. Entered and left at a negedge.
    task automatic measure(input int gap, input int limit,
                           output int ticks, output int kind);
        ticks = 0;
        kind  = 0;
        while (ticks < limit) begin
            osc_tick = 1'b1;
            @(negedge clk);
            osc_tick = 1'b0;
            ticks++;
            kind = {30'd0, wdt_wake, wdt_reset};
            if (kind != 0) break;
            for (int g = 1; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic pulse_clr();
        clr_strobe = 1'b1;
        @(negedge clk);
        clr_strobe = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        #(8 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin : main
        int t, k, gap, lim;
        repeat (3) @(negedge clk);
        // R8: outputs low under reset
        chk("R8 reset state", {wdt_wake, wdt_reset}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            ps_sel = VEC[v][26:23];
            hw_en  = VEC[v][22];
            sw_en  = VEC[v][21];
            in_pm  = VEC[v][20];
            gap    = int'(VEC[v][19:18]);
            pulse_clr();
            lim = (VEC[v][17:0] == 0) ? 3 * BD : int'(VEC[v][17:0]) + 4;
            measure(gap, lim, t, k);
            if (VEC[v][17:0] == 0) begin
                chk("R1 R2 inactive no pulse", k, 0);
            end else begin
                chk("R3 R4 period ticks", t, int'(VEC[v][17:0]));
                chk("R9 R10 pulse kind", k, VEC[v][20] ? 2 : 1);
                @(negedge clk);
                chk("R9 R10 single cycle", {wdt_wake, wdt_reset}, 0);
                if (VEC[v][17:0] < 100) begin
                    measure(gap, lim, t, k);
                    chk("R11 second period", t, int'(VEC[v][17:0]));
                end
            end
        end

        // Directed: sel 2 -> 8 ticks, running
        ps_sel = 4'd2; hw_en = 1; sw_en = 0; in_pm = 0;
        pulse_clr();

        // R8: async reset mid-count
        measure(1, 5, t, k);
        rst_n = 1'b0;
        #2;
        chk("R8 async clears outputs", {wdt_wake, wdt_reset}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        measure(1, 20, t, k);
        chk("R8 full period after reset", t, 8);

        // R5: service strobe mid-count
        measure(1, 5, t, k);
        pulse_clr();
        measure(1, 20, t, k);
        chk("R5 full period after clear", t, 8);

        // R6: sleep strobe mid-count
        measure(1, 5, t, k);
        sleep_strobe = 1'b1;
        @(negedge clk);
        sleep_strobe = 1'b0;
        measure(1, 20, t, k);
        chk("R6 full period after sleep", t, 8);

        // R7: clock failure mid-count
        measure(1, 5, t, k);
        clk_fail = 1'b1;
        @(negedge clk);
        clk_fail = 1'b0;
        measure(1, 20, t, k);
        chk("R7 full period after clock fail", t, 8);

        // R2: disable mid-count, ticks keep arriving, counters held at zero
        measure(1, 5, t, k);
        hw_en = 0; sw_en = 0;
        measure(1, 12, t, k);
        chk("R2 no pulse while inactive", k, 0);
        sw_en = 1;
        measure(1, 20, t, k);
        chk("R2 R1 full period after re-enable", t, 8);
        hw_en = 1;
        sw_en = 0;

        // R12: clear in the same cycle as the final tick
        ps_sel = 4'd1;
        pulse_clr();
        measure(1, 3, t, k);
        chk("R12 no early pulse", k, 0);
        osc_tick = 1'b1;
        clr_strobe = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
        clr_strobe = 1'b0;
        chk("R12 clear beats last tick", {wdt_wake, wdt_reset}, 0);
        @(negedge clk);
        chk("R12 still quiet", {wdt_wake, wdt_reset}, 0);
        measure(1, 10, t, k);
        chk("R12 full period after collision", t, 4);

        done = 1;
        summary();
    end
endmodule